// File: doc/BRIEF.md
# DS3 Alarm and Error Monitor Registers

This block sits beside a DS3 multiplexer's framer and turns its per-cycle event strobes into state that a processor can poll. A C-bit parity error pulse and seven DS2 tributary out-of-frame levels feed an 8-bit latched alarm register. Each alarm bit sets on the first sign of its alarm and holds until a processor read clears it.

Errored DS3 F-bit and M-bit pulses feed an 8-bit saturating counter. The counter freezes while the DS3 signal is lost or out of frame, and a read clears it.

One control bit, reset to one, inhibits the extra clock pulse that external C-bit logic uses to shift in the C3 bit. When the bit is zero, the pulse enable is driven high.

Register access uses a plain synchronous bus with an address, a read strobe and a write strobe. Read data appears on the clock edge after the strobe. It carries the register value from before any clearing effect of that read.

Top module: `m13_alarm_mon`

## Requirements
- R1: After reset the alarm register and the error counter read 0, the control register reads 1, and `c3_clk_en` is 0.
- R2: A one-cycle `cbit_err` pulse sets alarm bit 7 (address 0), and the bit stays set until the alarm register is read.
- R3: Any cycle in which `ds2_oof[k-1]` is high sets alarm bit k-1 for tributary k (k = 1..7). Bit 6 belongs to tributary 7 and bit 0 to tributary 1.
- R4: A read of address 0 returns the latched alarm byte on the next cycle and clears every bit that has no event in that same cycle.
- R5: A tributary out-of-frame level that is still high after a clearing read sets its bit again, so the next read shows it once more.
- R6: An alarm event in the same cycle as a clearing read leaves its bit set for the following read.
- R7: Each cycle adds `f_err` + `m_err` to the counter (address 1). An F-bit error and an M-bit error in the same cycle add 2.
- R8: The counter saturates at 255 and never wraps.
- R9: While `ds3_los` or `ds3_oof` is high, the counter does not change except through a clearing read.
- R10: A read of address 1 returns the count and then clears it. If an uninhibited error arrives in that same cycle, the counter holds that cycle's increment instead of 0.
- R11: A write to address 2 stores `bus_wdata[0]` as the inhibit bit, which reads back at address 2. `c3_clk_en` equals the inverse of that bit from the next cycle on. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cbit_err | input | 1 | C-bit parity error pulse (C1 seen as zero) |
| ds2_oof | input | 7 | Out-of-frame level per DS2 tributary; bit k-1 is tributary k |
| f_err | input | 1 | Errored DS3 F-bit pulse |
| m_err | input | 1 | Errored DS3 M-bit pulse |
| ds3_los | input | 1 | DS3 loss of signal |
| ds3_oof | input | 1 | DS3 out of frame |
| bus_addr | input | 2 | Register address: 0 alarms, 1 counter, 2 control |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| c3_clk_en | output | 1 | Enables the extra C3 clock pulse |

## Verification
The bench targets the cycle where a clearing read meets a new event.

- **Dropped event on clear:** if the clear wins over the event, an alarm or error is silently lost. This shows up as a missing bit or a count of 0 on the following read.
- **No re-arm:** a design without re-arm reports a persisting tributary alarm only once.
- **Counter wrap:** the counter is pushed well past 255, where a wrapping counter would read back a small number.
- **Inhibit ignored:** errors are applied under loss of signal and under out-of-frame, where a counter that ignores the inhibit keeps climbing.
- **Lane mapping:** every tributary lane is swept on its own, which exposes a reversed bit order.
- **Double error:** simultaneous F and M errors expose a counter that adds 1 instead of 2.

// File: rtl/m13_mon_pkg.sv
package m13_mon_pkg;
  parameter int unsigned DATA_W  = 8;
  parameter int unsigned N_TRIB  = 7;
  parameter int unsigned CNT_W   = 8;
  parameter int unsigned ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_ALARM = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/m13_sticky_bank.sv
module m13_sticky_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt,
  input  logic             clr,
  output logic [WIDTH-1:0] flags
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (evt[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/m13_sat_counter.sv
module m13_sat_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_a,
  input  logic             inc_b,
  input  logic             hold,
  input  logic             clr,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH:0] MAXV = {1'b0, {WIDTH{1'b1}}};

  logic [WIDTH:0] step;
  logic [WIDTH:0] base;
  logic [WIDTH:0] sum;

  always_comb begin
    step = hold ? '0 : ((WIDTH+1)'(inc_a) + (WIDTH+1)'(inc_b));
    base = clr ? '0 : {1'b0, count};
    sum  = base + step;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (sum > MAXV) count <= MAXV[WIDTH-1:0];
    else              count <= sum[WIDTH-1:0];
  end
endmodule

// File: rtl/m13_alarm_mon.sv
module m13_alarm_mon
  import m13_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cbit_err,
  input  logic [N_TRIB-1:0] ds2_oof,
  input  logic              f_err,
  input  logic              m_err,
  input  logic              ds3_los,
  input  logic              ds3_oof,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              c3_clk_en
);
  localparam int unsigned ALARM_W = N_TRIB + 1;

  logic [ALARM_W-1:0] stat_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               inhibit_q;
  logic               rd_alarm, rd_count;

  assign rd_alarm = bus_rd && (bus_addr == REG_ALARM);
  assign rd_count = bus_rd && (bus_addr == REG_COUNT);

  m13_sticky_bank #(.WIDTH(ALARM_W)) alarm_i (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   ({cbit_err, ds2_oof}),
    .clr   (rd_alarm),
    .flags (stat_q)
  );

  m13_sat_counter #(.WIDTH(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_a (f_err),
    .inc_b (m_err),
    .hold  (ds3_los || ds3_oof),
    .clr   (rd_count),
    .count (cnt_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                                inhibit_q <= 1'b1;
    else if (bus_wr && bus_addr == REG_CTRL)   inhibit_q <= bus_wdata[0];
  end

  assign c3_clk_en = ~inhibit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        REG_ALARM: bus_rdata <= DATA_W'(stat_q);
        REG_COUNT: bus_rdata <= DATA_W'(cnt_q);
        REG_CTRL:  bus_rdata <= DATA_W'(inhibit_q);
        default:   bus_rdata <= '0;
      endcase
    end else bus_rdata <= '0;
  end
endmodule

// File: rtl/m13_alarm_mon_chk.sv
module m13_alarm_mon_chk
  import m13_mon_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cbit_err,
  input logic [N_TRIB-1:0] ds2_oof,
  input logic              ds3_los,
  input logic              ds3_oof,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              c3_clk_en,
  input logic [N_TRIB:0]   stat_q,
  input logic [CNT_W-1:0]  cnt_q
);
  // R2
  cbit_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cbit_err |=> stat_q[N_TRIB]);

  // R4
  alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_ALARM && !cbit_err && ds2_oof == '0) |=> stat_q == '0);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CNT_W{1'b1}} && !(bus_rd && bus_addr == REG_COUNT)) |=> cnt_q == {CNT_W{1'b1}});

  // R9
  count_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ds3_los || ds3_oof) && !(bus_rd && bus_addr == REG_COUNT)) |=> $stable(cnt_q));

  // R11
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_CTRL) |=> c3_clk_en == !$past(bus_wdata[0]));
endmodule

bind m13_alarm_mon m13_alarm_mon_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cbit_err  (cbit_err),
  .ds2_oof   (ds2_oof),
  .ds3_los   (ds3_los),
  .ds3_oof   (ds3_oof),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .c3_clk_en (c3_clk_en),
  .stat_q    (stat_q),
  .cnt_q     (cnt_q)
);

// File: tb/m13_alarm_mon_tb.sv
module m13_alarm_mon_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cbit_err = 1'b0;
  logic [6:0] ds2_oof = '0;
  logic       f_err = 1'b0, m_err = 1'b0;
  logic       ds3_los = 1'b0, ds3_oof = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       c3_clk_en;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  m13_alarm_mon dut_i (.*);

  task automatic step();
    @(posedge clk); #1;
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // read with the read strobe in one cycle; data sampled just after that edge
  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic errs(int nf, int nb);
    for (int i = 0; i < nf; i++) begin f_err = i[0]; m_err = !i[0]; step(); end
    for (int i = 0; i < nb; i++) begin f_err = 1; m_err = 1; step(); end
    f_err = 0; m_err = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 c3_clk_en", c3_clk_en, 0);
    rd(2'd0, v); check("R1 alarm", v, 0);
    rd(2'd1, v); check("R1 count", v, 0);
    rd(2'd2, v); check("R1 ctrl", v, 1);

    // R2 C-bit error latch
    cbit_err = 1; step(); cbit_err = 0;
    step(); step();
    rd(2'd0, v); check("R2 set", v, 8'h80);
    rd(2'd0, v); check("R4 cleared", v, 0);

    // R3 per-tributary sweep
    for (int k = 1; k <= 7; k++) begin
      ds2_oof = 7'(1 << (k - 1)); step(); ds2_oof = '0; step();
      rd(2'd0, v); check("R3 tributary", v, 1 << (k - 1));
      rd(2'd0, v); check("R4 clear", v, 0);
    end

    // R5 re-arm while the condition persists
    ds2_oof = 7'h04; step();
    rd(2'd0, v); check("R5 first", v, 8'h04);
    rd(2'd0, v); check("R5 rearm", v, 8'h04);
    ds2_oof = '0; step();
    rd(2'd0, v); check("R5 after drop", v, 8'h04);
    rd(2'd0, v); check("R5 gone", v, 0);

    // R6 event in the same cycle as the clearing read
    ds2_oof = 7'h40; step(); ds2_oof = '0;
    cbit_err = 1; rd(2'd0, v); cbit_err = 0;
    check("R6 read value", v, 8'h40);
    rd(2'd0, v); check("R6 kept", v, 8'h80);
    rd(2'd0, v); check("R6 cleared", v, 0);

    // R7 counting sweep with singles and doubles
    for (int n = 0; n <= 12; n++) begin
      for (int b = 0; b <= 3; b++) begin
        errs(n, b);
        rd(2'd1, v); check("R7 count", v, n + 2 * b);
      end
    end

    // R8 saturation
    errs(10, 140); rd(2'd1, v); check("R8 saturate", v, 255);
    errs(255, 0);  rd(2'd1, v); check("R8 exact", v, 255);
    rd(2'd1, v); check("R10 cleared", v, 0);

    // R9 freeze under LOS and OOF
    errs(5, 0);
    ds3_los = 1; errs(6, 3); ds3_los = 0;
    ds3_oof = 1; errs(4, 2); ds3_oof = 0;
    errs(0, 1);
    rd(2'd1, v); check("R9 freeze", v, 7);

    // R10 error in the read cycle
    errs(4, 0);
    f_err = 1; m_err = 1; rd(2'd1, v); f_err = 0; m_err = 0;
    check("R10 read value", v, 4);
    rd(2'd1, v); check("R10 carry", v, 2);
    errs(3, 0);
    ds3_oof = 1; f_err = 1; rd(2'd1, v); f_err = 0; ds3_oof = 0;
    check("R10 read value", v, 3);
    rd(2'd1, v); check("R10 inhibited carry", v, 0);

    // R11 control bit
    wr(2'd2, 8'h00); check("R11 enable", c3_clk_en, 1);
    rd(2'd2, v); check("R11 readback 0", v, 0);
    wr(2'd2, 8'hFF); check("R11 inhibit", c3_clk_en, 0);
    rd(2'd2, v); check("R11 readback 1", v, 1);
    rd(2'd3, v); check("R11 unused addr", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule